// File: doc/BRIEF.md
# Cascadable Column Sampling Strobe Sequencer

This block drives the sampling select lines of a column driver whose columns share three video input lanes. Lane A feeds columns 3n, lane B feeds 3n+1 and lane C feeds 3n+2, so one group strobe `grp_stb_o[n]` together with a one-hot lane mask `lane_o` names the column (or columns) being sampled. Each rising edge of the shift clock moves the selection one step in the chosen direction. In per-column mode each step selects one column. In grouped mode each step selects all three columns of a group.

Drivers are chained through active-low cascade pins. The first driver has its enable tied low. Each driver pulls its forward cascade output low on the second-to-last step of its own scan, which lets the next driver start on the rising edge right after this driver's last step, with no gap and no controller involvement. When the direction is reversed, the input and output roles of the two cascade pins swap.

A line-latch pulse clears the cascade output and re-arms the sequencer. The shift clock and line pulse are sampled with the fast system clock and handled by edge detection, so the whole block runs in one synchronous domain. A gated copy of the shift clock is produced only while the sequencer is engaged.

States:
- `ST_ARMED`: idle, waiting for the enable.
- `ST_READY`: enable seen on a shift-clock rise; waiting for the next rise.
- `ST_SCAN`: strobing steps.
- `ST_DONE`: final step passed; strobes are held low.

Transitions:
- ARMED to READY: a shift rise with the enable active.
- READY to SCAN: the next shift rise.
- SCAN to SCAN: a shift rise before the last step.
- SCAN to DONE: a shift rise on the last step.
- Any state to ARMED: the line pulse is high.

Top module: `strobe_seq`

## Requirements
- R1: After reset, `grp_stb_o` and `lane_o` are all zero, both cascade outputs are high, and `gclk_o` is low.
- R2: The first shift-clock rise that sees the enable active produces no strobe. The following rise strobes the first step.
- R3: In per-column mode with `dir_up_i`=1, step k (k=0..NCOL-1) selects column c=k. The selection is shown as `grp_stb_o` = one-hot bit c/3, and `lane_o` = one-hot bit c%3 (bit 0 = lane A, bit 1 = lane B, bit 2 = lane C).
- R4: In per-column mode with `dir_up_i`=0, step k selects column c=NCOL-1-k, with the same encoding as R3.
- R5: In grouped mode (`grouped_i`=1), `lane_o`=3'b111 while strobing. Step k selects group k when scanning up, and group NGRP-1-k when scanning down, where NGRP=(NCOL+2)/3.
- R6: The forward cascade output goes low on the rise that strobes the second-to-last step, and stays low until the line pulse. The forward output is `cas_hi_n_o` when scanning up and `cas_lo_n_o` when scanning down. The other cascade output stays high.
- R7: After the last step, strobes are zero, and further shift rises neither strobe nor change the cascade outputs.
- R8: A line pulse clears the strobes and the cascade output and re-arms the sequencer. A new scan then again needs two shift rises (R2).
- R9: `gclk_o` follows the shift clock, two system cycles late, only in READY and SCAN. It is low while the sequencer is armed but not enabled, and after the scan is done.
- R10: The enable input is `cas_lo_n_i` when scanning up and `cas_hi_n_i` when scanning down. While the selected pin is high, shift rises cause no strobe, even if the other pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_clk_i | input | 1 | Shift clock (sampled) |
| line_pulse_i | input | 1 | Line-latch pulse, high only while the shift clock is low |
| dir_up_i | input | 1 | 1: scan columns upward; 0: scan downward |
| grouped_i | input | 1 | 1: one step per three-column group; 0: one step per column |
| cas_lo_n_i | input | 1 | Low-side cascade pin, enable input when scanning up |
| cas_hi_n_i | input | 1 | High-side cascade pin, enable input when scanning down |
| cas_lo_n_o | output | 1 | Low-side cascade output, forward enable when scanning down |
| cas_hi_n_o | output | 1 | High-side cascade output, forward enable when scanning up |
| grp_stb_o | output | NGRP | One-hot group strobe |
| lane_o | output | 3 | One-hot lane mask (A, B, C), all ones in grouped mode |
| gclk_o | output | 1 | Gated shift clock |

## Verification
A wrong position counter shows up at the very next shift rise as a wrong group bit or lane bit, so every step of every scan is compared against the column computed from the step number. A wrong step count or a missed state change shows as a forward enable that falls one step early or late, or as strobes that carry on past the last step. These appear within one shift period of the fault. A line pulse that fails to clear state shows on the first two shift rises of the next line: the strobe appears too soon, or the cascade output stays low.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_READY = 2'd1,
        ST_SCAN  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/strobe_edge_sampler.sv
module strobe_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk_i,
    input  logic line_pulse_i,
    output logic shift_lvl,
    output logic shift_rise,
    output logic line_lvl
);
    logic sh_q, sh_qq, lp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= 1'b0;
            sh_qq <= 1'b0;
            lp_q  <= 1'b0;
        end else begin
            sh_q  <= shift_clk_i;
            sh_qq <= sh_q;
            lp_q  <= line_pulse_i;
        end
    end

    assign shift_lvl  = sh_q;
    assign shift_rise = sh_q & ~sh_qq;
    assign line_lvl   = lp_q;
endmodule

// File: rtl/strobe_pos_walker.sv
module strobe_pos_walker #(
    parameter int NCOL = 160,
    localparam int NGRP = (NCOL + 2) / 3,
    localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          up,
    input  logic          grouped,
    output logic [GW-1:0] grp,
    output logic [2:0]    lane_mask
);
    localparam logic [GW-1:0] TOP_COL_GRP  = GW'((NCOL - 1) / 3);
    localparam logic [1:0]    TOP_COL_LANE = 2'((NCOL - 1) % 3);
    localparam logic [GW-1:0] TOP_GRP      = GW'(NGRP - 1);

    logic [1:0] lane_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp    <= '0;
            lane_q <= '0;
        end else if (load) begin
            if (up) begin
                grp    <= '0;
                lane_q <= 2'd0;
            end else begin
                grp    <= grouped ? TOP_GRP : TOP_COL_GRP;
                lane_q <= grouped ? 2'd0 : TOP_COL_LANE;
            end
        end else if (step) begin
            if (grouped) begin
                grp <= up ? grp + 1'b1 : grp - 1'b1;
            end else if (up) begin
                if (lane_q == 2'd2) begin
                    lane_q <= 2'd0;
                    grp    <= grp + 1'b1;
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end else begin
                if (lane_q == 2'd0) begin
                    lane_q <= 2'd2;
                    grp    <= grp - 1'b1;
                end else begin
                    lane_q <= lane_q - 1'b1;
                end
            end
        end
    end

    assign lane_mask = grouped ? 3'b111 : (3'b001 << lane_q);
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
    import strobe_seq_pkg::*;
#(
    parameter int NCOL = 160,
    localparam int NGRP = (NCOL + 2) / 3,
    localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int SW = $clog2(NCOL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_clk_i,
    input  logic            line_pulse_i,
    input  logic            dir_up_i,
    input  logic            grouped_i,
    input  logic            cas_lo_n_i,
    input  logic            cas_hi_n_i,
    output logic            cas_lo_n_o,
    output logic            cas_hi_n_o,
    output logic [NGRP-1:0] grp_stb_o,
    output logic [2:0]      lane_o,
    output logic            gclk_o
);
    localparam logic [SW-1:0] LAST_COL = SW'(NCOL - 1);
    localparam logic [SW-1:0] LAST_GRP = SW'(NGRP - 1);

    seq_state_t      state_q, state_d;
    logic            shift_lvl, shift_rise, line_lvl;
    logic            dir_q, mode_q, handoff_q;
    logic [SW-1:0]   step_q, last_step;
    logic            enable_act, walk_load, walk_step;
    logic [GW-1:0]   grp;
    logic [2:0]      lane_mask;

    strobe_edge_sampler u_samp (
        .clk(clk), .rst_n(rst_n),
        .shift_clk_i(shift_clk_i), .line_pulse_i(line_pulse_i),
        .shift_lvl(shift_lvl), .shift_rise(shift_rise), .line_lvl(line_lvl)
    );

    assign enable_act = dir_up_i ? ~cas_lo_n_i : ~cas_hi_n_i;
    assign last_step  = mode_q ? LAST_GRP : LAST_COL;
    assign walk_load  = !line_lvl && shift_rise && (state_q == ST_READY);
    assign walk_step  = !line_lvl && shift_rise && (state_q == ST_SCAN)
                        && (step_q != last_step);

    strobe_pos_walker #(.NCOL(NCOL)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(walk_load), .step(walk_step),
        .up(dir_q), .grouped(mode_q), .grp(grp), .lane_mask(lane_mask)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (line_lvl) begin
            state_d = ST_ARMED;
        end else if (shift_rise) begin
            unique case (state_q)
                ST_ARMED: if (enable_act) state_d = ST_READY;
                ST_READY: state_d = ST_SCAN;
                ST_SCAN:  if (step_q == last_step) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // step count, latched configuration, handoff and gated clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= '0;
            dir_q     <= 1'b1;
            mode_q    <= 1'b0;
            handoff_q <= 1'b0;
            gclk_o    <= 1'b0;
        end else begin
            gclk_o <= shift_lvl && ((state_q == ST_READY) || (state_q == ST_SCAN));
            if (line_lvl) begin
                handoff_q <= 1'b0;
            end else if (shift_rise && (state_q == ST_ARMED) && enable_act) begin
                dir_q  <= dir_up_i;
                mode_q <= grouped_i;
            end else if (walk_load) begin
                step_q <= '0;
            end else if (walk_step) begin
                step_q <= step_q + 1'b1;
                if (step_q + 1'b1 == last_step - 1'b1) handoff_q <= 1'b1;
            end
        end
    end

    assign cas_hi_n_o = ~(handoff_q & dir_q);
    assign cas_lo_n_o = ~(handoff_q & ~dir_q);
    assign lane_o     = (state_q == ST_SCAN) ? lane_mask : 3'b000;

    for (genvar g = 0; g < NGRP; g++) begin : g_stb
        assign grp_stb_o[g] = (state_q == ST_SCAN) && (grp == GW'(g));
    end
endmodule

// File: rtl/strobe_seq_checker.sv
module strobe_seq_checker #(
    parameter int NGRP = 54
) (
    input logic            clk,
    input logic            rst_n,
    input logic            shift_clk_i,
    input logic            line_pulse_i,
    input logic            cas_lo_n_o,
    input logic            cas_hi_n_o,
    input logic [NGRP-1:0] grp_stb_o,
    input logic [2:0]      lane_o,
    input logic            gclk_o
);
    assert_stb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_stb_o));

    assert_lane_with_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_stb_o != '0) |-> (lane_o != 3'b000));

    assert_single_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lo_n_o || cas_hi_n_o));

    assert_line_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse_i && $past(line_pulse_i) && $past(line_pulse_i, 2))
        |-> (grp_stb_o == '0 && cas_lo_n_o && cas_hi_n_o));

    assert_gclk_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gclk_o |-> $past(shift_clk_i, 2));
endmodule

bind strobe_seq strobe_seq_checker #(.NGRP(NGRP)) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_clk_i(shift_clk_i),
    .line_pulse_i(line_pulse_i), .cas_lo_n_o(cas_lo_n_o),
    .cas_hi_n_o(cas_hi_n_o), .grp_stb_o(grp_stb_o), .lane_o(lane_o),
    .gclk_o(gclk_o)
);

// File: tb/sim_strobe_seq.sv
`timescale 1ns/1ps
module sim_strobe_seq;
    localparam int NCOL = 160;
    localparam int NGRP = (NCOL + 2) / 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_clk_i = 1'b0, line_pulse_i = 1'b0;
    logic dir_up_i = 1'b1, grouped_i = 1'b0;
    logic cas_lo_n_i = 1'b1, cas_hi_n_i = 1'b1;
    logic cas_lo_n_o, cas_hi_n_o, gclk_o;
    logic [NGRP-1:0] grp_stb_o;
    logic [2:0] lane_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic last_g;

    always #2 clk = ~clk;

    strobe_seq #(.NCOL(NCOL)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(shift_clk_i),
        .line_pulse_i(line_pulse_i), .dir_up_i(dir_up_i), .grouped_i(grouped_i),
        .cas_lo_n_i(cas_lo_n_i), .cas_hi_n_i(cas_hi_n_i),
        .cas_lo_n_o(cas_lo_n_o), .cas_hi_n_o(cas_hi_n_o),
        .grp_stb_o(grp_stb_o), .lane_o(lane_o), .gclk_o(gclk_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_pulse();
        shift_clk_i = 1'b1;
        tick(4);
        last_g = gclk_o;
        shift_clk_i = 1'b0;
        tick(4);
    endtask

    task automatic line_pulse();
        line_pulse_i = 1'b1;
        tick(4);
        line_pulse_i = 1'b0;
        tick(4);
    endtask

    task automatic chk_outputs(input string req, input logic [NGRP-1:0] eg,
                               input logic [2:0] el, input logic elo, input logic ehi);
        chk(grp_stb_o == eg, req, grp_stb_o, eg);
        chk(lane_o == el, req, lane_o, el);
        chk({cas_lo_n_o, cas_hi_n_o} == {elo, ehi}, req, {cas_lo_n_o, cas_hi_n_o}, {elo, ehi});
    endtask

    task automatic run_scan(input logic up, input logic grp_mode);
        int nsteps;
        int c;
        int g;
        logic [2:0] el;
        logic fwd;
        nsteps = grp_mode ? NGRP : NCOL;
        dir_up_i = up;
        grouped_i = grp_mode;
        cas_lo_n_i = up ? 1'b0 : 1'b1;
        cas_hi_n_i = up ? 1'b1 : 1'b0;
        line_pulse();
        shift_pulse();
        chk_outputs("R2 first rise", '0, 3'b000, 1'b1, 1'b1);
        for (int k = 0; k < nsteps; k++) begin
            shift_pulse();
            if (grp_mode) begin
                g = up ? k : NGRP - 1 - k;
                el = 3'b111;
            end else begin
                c = up ? k : NCOL - 1 - k;
                g = c / 3;
                el = 3'b001 << (c % 3);
            end
            fwd = (k >= nsteps - 2);
            if (grp_mode)
                chk_outputs("R5/R6 grouped step", NGRP'(1) << g, el,
                            up ? 1'b1 : ~fwd, up ? ~fwd : 1'b1);
            else if (up)
                chk_outputs("R3/R6 up step", NGRP'(1) << g, el, 1'b1, ~fwd);
            else
                chk_outputs("R4/R6 down step", NGRP'(1) << g, el, ~fwd, 1'b1);
            if (k == 1) chk(last_g == 1'b1, "R9 gclk in scan", last_g, 1);
        end
        shift_pulse();
        chk_outputs("R7 after last", '0, 3'b000, up ? 1'b1 : 1'b0, up ? 1'b0 : 1'b1);
        chk(last_g == 1'b0, "R9 gclk after done", last_g, 0);
        shift_pulse();
        chk_outputs("R7 ignored rise", '0, 3'b000, up ? 1'b1 : 1'b0, up ? 1'b0 : 1'b1);
        line_pulse();
        chk_outputs("R8 line clears", '0, 3'b000, 1'b1, 1'b1);
        shift_pulse();
        chk_outputs("R8 rearm first rise", '0, 3'b000, 1'b1, 1'b1);
        shift_pulse();
        g = grp_mode ? (up ? 0 : NGRP - 1) : (up ? 0 : (NCOL - 1) / 3);
        el = grp_mode ? 3'b111 : (up ? 3'b001 : 3'b001 << ((NCOL - 1) % 3));
        chk_outputs("R8 rearm restart", NGRP'(1) << g, el, 1'b1, 1'b1);
        line_pulse();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk_outputs("R1 reset", '0, 3'b000, 1'b1, 1'b1);
        chk(gclk_o == 1'b0, "R1 gclk reset", gclk_o, 0);
        rst_n = 1'b1;
        tick(2);

        // R10 enable inactive: nothing strobes, gclk stays low (R9)
        dir_up_i = 1'b1;
        cas_lo_n_i = 1'b1;
        cas_hi_n_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            shift_pulse();
            chk_outputs("R10 wrong pin enable", '0, 3'b000, 1'b1, 1'b1);
            chk(last_g == 1'b0, "R9 gclk while disabled", last_g, 0);
        end
        dir_up_i = 1'b0;
        cas_lo_n_i = 1'b0;
        cas_hi_n_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            shift_pulse();
            chk_outputs("R10 down wrong pin", '0, 3'b000, 1'b1, 1'b1);
        end

        for (int d = 1; d >= 0; d--) begin
            for (int m = 0; m < 2; m++) begin
                run_scan(d[0], m[0]);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule